// File: doc/BRIEF.md
# DRAM Bank Locality Monitor

This block sits beside one memory controller and watches the commands issued to its DRAM banks. It keeps, for every bank, a copy of which row that bank's row buffer holds. Each reported access is then sorted into a hit or a miss. A hit means the access targets the row already held. A miss means another row, or no row, was held. At the same time the block watches a vector of per-bank busy flags. In each cycle where at least one bank is busy, it adds the number of busy banks to a running sum and counts that cycle as active.

Software finds row-buffer locality by dividing hits by accesses. It finds bank-level parallelism by dividing the busy-bank sum by the active-cycle count. So the block keeps only the four raw totals. A snapshot strobe copies all four totals into shadow registers in one cycle, so that one consistent set is read out through a two-bit select. A clear strobe restarts the measurement. The bank count, the row-address width and the counter width are parameters.

Top module: `bank_locality_monitor`

## Requirements
- R1: An access whose row equals the row currently open in its bank is a hit: both the hit total and the access total rise by one.
- R2: An access to a bank holding a different row is a miss. Only the access total rises, and the new row replaces the old one, so a later access to the old row is also a miss.
- R3: After reset or clear no bank holds an open row, so the first access to any bank is a miss.
- R4: Banks keep independent open rows; an access to one bank never changes the row recorded for another.
- R5: In every cycle with at least one busy flag set, the busy-bank sum grows by the number of set flags and the active-cycle total grows by one.
- R6: A cycle with no busy flag set changes neither the busy-bank sum nor the active-cycle total.
- R7: Every total saturates at 2^CNT_W-1 and stays there instead of wrapping.
- R8: A clear strobe zeroes all four totals and closes every open row. Accesses and busy flags in the clear cycle are ignored.
- R9: A snapshot strobe copies all four totals at once, as they stood before that cycle's events. The shadow copy holds until the next snapshot. The select rd_addr reads 0 = hits, 1 = accesses, 2 = busy-bank sum, 3 = active cycles.
- R10: After reset every shadow register reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Zero totals and close all rows |
| snap | input | 1 | Copy totals into shadow registers |
| acc_valid | input | 1 | An access is reported this cycle |
| acc_bank | input | BANK_W | Bank of the access |
| acc_row | input | ROW_W | Row of the access |
| bank_busy | input | NUM_BANKS | Per-bank request-in-service flags |
| rd_addr | input | 2 | Shadow register select |
| rd_data | output | CNT_W | Selected shadow register |

## Verification
The assertions assume that NUM_BANKS is a power of two, so every value of acc_bank names a real bank. They also assume that clear and snap are ordinary synchronous strobes sampled at the rising edge. The stimulus uses only bank indices below the bank count and drives all inputs on the falling edge. Readout takes place with access, busy, clear and snap held low, so that idle readout cycles leave the reference totals unchanged.

// File: rtl/lmon_pkg.sv
package lmon_pkg;
    localparam int NUM_TOTALS = 4;

    typedef enum logic [1:0] {
        SEL_HITS     = 2'd0,
        SEL_ACCESSES = 2'd1,
        SEL_BUSY_SUM = 2'd2,
        SEL_ACTIVE   = 2'd3
    } lmon_sel_e;
endpackage

// File: rtl/lmon_row_table.sv
module lmon_row_table #(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 14,
    parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              acc_valid,
    input  logic [BANK_W-1:0] acc_bank,
    input  logic [ROW_W-1:0]  acc_row,
    output logic              lookup_hit
);
    typedef struct packed {
        logic [NUM_BANKS-1:0]            open;
        logic [NUM_BANKS-1:0][ROW_W-1:0] row;
    } table_t;

    table_t tbl_d, tbl_q;
    logic [NUM_BANKS-1:0] match;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_match
        assign match[g] = tbl_q.open[g] && (tbl_q.row[g] == acc_row);
    end

    assign lookup_hit = acc_valid && match[acc_bank];

    always_comb begin
        tbl_d = tbl_q;
        if (clr) begin
            tbl_d.open = '0;
        end else if (acc_valid) begin
            tbl_d.open[acc_bank] = 1'b1;
            tbl_d.row[acc_bank]  = acc_row;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assert_clear_closes_rows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (tbl_q.open == '0));

    assert_access_opens_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && acc_valid) |=> (tbl_q.open[$past(acc_bank)] &&
                                 tbl_q.row[$past(acc_bank)] == $past(acc_row)));

    assert_no_row_after_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_q.open == '0) |-> !lookup_hit);
endmodule

// File: rtl/lmon_sat_acc.sv
module lmon_sat_acc #(
    parameter int CNT_W = 32,
    parameter int INC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc_en,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   sum;

    always_comb begin
        sum   = {1'b0, cnt_q} + (CNT_W+1)'(inc);
        cnt_d = cnt_q;
        if (clr)         cnt_d = '0;
        else if (inc_en) cnt_d = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    assert_never_wraps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt_q >= $past(cnt_q)));

    assert_saturated_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt_q == '1) |=> (cnt_q == '1));
endmodule

// File: rtl/bank_locality_monitor.sv
module bank_locality_monitor
    import lmon_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 14,
    parameter int CNT_W     = 32,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 snap,
    input  logic                 acc_valid,
    input  logic [BANK_W-1:0]    acc_bank,
    input  logic [ROW_W-1:0]     acc_row,
    input  logic [NUM_BANKS-1:0] bank_busy,
    input  logic [1:0]           rd_addr,
    output logic [CNT_W-1:0]     rd_data
);
    localparam int INC_W = $clog2(NUM_BANKS + 1);

    typedef struct packed {
        logic [NUM_TOTALS-1:0][CNT_W-1:0] total;
    } shadow_t;

    logic                             is_hit;
    logic                             any_busy;
    logic [INC_W-1:0]                 busy_pop;
    logic [NUM_TOTALS-1:0]            inc_en;
    logic [NUM_TOTALS-1:0][INC_W-1:0] inc_val;
    logic [NUM_TOTALS-1:0][CNT_W-1:0] totals;
    shadow_t                          shd_d, shd_q;

    lmon_row_table #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ROW_W),
        .BANK_W    (BANK_W)
    ) u_rows (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clear),
        .acc_valid  (acc_valid),
        .acc_bank   (acc_bank),
        .acc_row    (acc_row),
        .lookup_hit (is_hit)
    );

    always_comb begin
        busy_pop = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            busy_pop = busy_pop + INC_W'(bank_busy[i]);
        end
        any_busy = |bank_busy;

        inc_en[SEL_HITS]      = is_hit;
        inc_val[SEL_HITS]     = INC_W'(1);
        inc_en[SEL_ACCESSES]  = acc_valid;
        inc_val[SEL_ACCESSES] = INC_W'(1);
        inc_en[SEL_BUSY_SUM]  = any_busy;
        inc_val[SEL_BUSY_SUM] = busy_pop;
        inc_en[SEL_ACTIVE]    = any_busy;
        inc_val[SEL_ACTIVE]   = INC_W'(1);
    end

    for (genvar g = 0; g < NUM_TOTALS; g++) begin : g_total
        lmon_sat_acc #(
            .CNT_W (CNT_W),
            .INC_W (INC_W)
        ) u_acc (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clear),
            .inc_en (inc_en[g]),
            .inc    (inc_val[g]),
            .count  (totals[g])
        );
    end

    always_comb begin
        shd_d = shd_q;
        if (snap) shd_d.total = totals;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shd_q <= '0;
        else        shd_q <= shd_d;
    end

    assign rd_data = shd_q.total[rd_addr];

    assert_hits_le_accesses_R1: assert property (@(posedge clk) disable iff (!rst_n)
        totals[SEL_HITS] <= totals[SEL_ACCESSES]);

    assert_busy_sum_covers_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
        totals[SEL_BUSY_SUM] >= totals[SEL_ACTIVE]);

    assert_idle_cycle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !(|bank_busy)) |=> ($stable(totals[SEL_ACTIVE]) &&
                                       $stable(totals[SEL_BUSY_SUM])));

    assert_clear_zeroes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (totals == '0));

    assert_snapshot_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (shd_q.total == $past(totals)));

    assert_shadow_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !snap |=> $stable(shd_q));
endmodule

// File: tb/bank_locality_monitor_bench.sv
`timescale 1ns/1ps
module bank_locality_monitor_bench;
    localparam int NB   = 8;
    localparam int RW   = 14;
    localparam int CW   = 6;
    localparam int BW   = $clog2(NB);
    localparam int MAXV = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic          snap = 1'b0;
    logic          acc_valid = 1'b0;
    logic [BW-1:0] acc_bank = '0;
    logic [RW-1:0] acc_row = '0;
    logic [NB-1:0] bank_busy = '0;
    logic [1:0]    rd_addr = '0;
    logic [CW-1:0] rd_data;

    always #2.5 clk = ~clk;

    bank_locality_monitor #(.NUM_BANKS(NB), .ROW_W(RW), .CNT_W(CW)) u_bank_locality_monitor (
        .clk(clk), .rst_n(rst_n), .clear(clear), .snap(snap),
        .acc_valid(acc_valid), .acc_bank(acc_bank), .acc_row(acc_row),
        .bank_busy(bank_busy), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    typedef struct {
        string tag;
        int    v[4];
    } exp_t;

    exp_t exp_q[$];
    exp_t last_snap;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    int   m_tot[4];
    bit   m_open[NB];
    int   m_row[NB];

    function automatic int sat_add(int a, int b);
        return (a + b > MAXV) ? MAXV : a + b;
    endfunction

    function automatic void model_reset_all();
        for (int i = 0; i < 4; i++) m_tot[i] = 0;
        for (int i = 0; i < NB; i++) begin m_open[i] = 0; m_row[i] = 0; end
    endfunction

    task automatic step(input bit v, input int b, input int r, input logic [NB-1:0] busy,
                        input bit clr, input bit snp, input string tag);
        int pop;
        @(negedge clk);
        acc_valid = v; acc_bank = BW'(b); acc_row = RW'(r);
        bank_busy = busy; clear = clr; snap = snp;
        @(posedge clk);
        if (snp) begin
            exp_t e;
            e.tag = tag;
            for (int i = 0; i < 4; i++) e.v[i] = m_tot[i];
            exp_q.push_back(e);
            last_snap = e;
        end
        if (clr) begin
            model_reset_all();
        end else begin
            if (v) begin
                if (m_open[b] && m_row[b] == r) m_tot[0] = sat_add(m_tot[0], 1);
                m_tot[1] = sat_add(m_tot[1], 1);
                m_open[b] = 1; m_row[b] = r;
            end
            pop = $countones(busy);
            if (pop != 0) begin
                m_tot[2] = sat_add(m_tot[2], pop);
                m_tot[3] = sat_add(m_tot[3], 1);
            end
        end
    endtask

    task automatic expect_hold(input string tag);
        exp_t e;
        e = last_snap;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: pops expected items and compares the shadow readout
    task automatic drain();
        string names[4] = '{"hits", "accesses", "busy_sum", "active"};
        @(negedge clk);
        acc_valid = 0; clear = 0; snap = 0; bank_busy = '0;
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            for (int a = 0; a < 4; a++) begin
                @(negedge clk);
                rd_addr = 2'(a);
                #1;
                checks++;
                if (int'(rd_data) != e.v[a]) begin
                    failures++;
                    $display("FAIL %s %s: actual=%0d expected=%0d", e.tag, names[a],
                             int'(rd_data), e.v[a]);
                end
            end
        end
    endtask

    initial begin
        model_reset_all();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R10: shadow registers are zero after reset
        begin
            exp_t z;
            z.tag = "R10";
            for (int i = 0; i < 4; i++) z.v[i] = 0;
            exp_q.push_back(z);
            last_snap = z;
        end
        drain();

        // R1 R2 R3 R4: hit and miss classification
        step(1, 0, 5, '0, 0, 0, "");
        step(1, 0, 5, '0, 0, 0, "");
        step(1, 1, 5, '0, 0, 0, "");
        step(1, 0, 7, '0, 0, 0, "");
        step(1, 0, 5, '0, 0, 0, "");
        step(1, 0, 5, '0, 0, 0, "");
        step(1, 1, 5, '0, 0, 0, "");
        step(0, 0, 0, '0, 0, 1, "R1 R2 R3 R4 classify");
        drain();

        // R5 R6: busy-bank sum and active cycles
        repeat (3) step(0, 0, 0, 8'b0000_0101, 0, 0, "");
        repeat (2) step(0, 0, 0, 8'b0000_0000, 0, 0, "");
        step(0, 0, 0, 8'hFF, 0, 0, "");
        step(0, 0, 0, 8'b1000_0000, 0, 0, "");
        step(0, 0, 0, '0, 0, 1, "R5 R6 busy");
        drain();

        // R9: snapshot excludes same-cycle events, shadow holds afterwards
        step(1, 2, 1, 8'h01, 0, 1, "R9 same-cycle");
        step(1, 2, 1, 8'h03, 0, 0, "");
        drain();
        step(1, 3, 4, 8'h0F, 0, 0, "");
        expect_hold("R9 hold");
        drain();
        step(0, 0, 0, '0, 0, 1, "R9 fresh");
        drain();

        // R8 R3: clear ignores same-cycle events and closes rows
        step(1, 0, 5, 8'hFF, 1, 0, "");
        step(1, 0, 5, '0, 0, 0, "");
        step(0, 0, 0, '0, 0, 1, "R8 R3 clear");
        drain();

        // R7: saturation of every total
        for (int k = 0; k < 70; k++) step(1, 3, 9, 8'hFF, 0, 0, "");
        step(0, 0, 0, '0, 0, 1, "R7 saturate");
        drain();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule